// File: doc/BRIEF.md
# SCK Prescaler

This block turns the core clock into the half-period events of a serial-peripheral clock. Every half period it raises a one-cycle toggle strobe. The strobe is tagged as the leading (sample) edge or the trailing (shift) edge of the SCK period. A shift-register engine uses these strobes to drive SCK and to move data. It needs no second clock domain.

The divisor comes from an 8-bit prescale field that software writes. A build-time parameter selects one of two encodings:

- **Legacy encoding:** the low nibble gives half of an even divisor.
- **Extended encoding:** a 4-bit multiplier is shifted left by a 3-bit exponent. The three exponent bits are spread over the field.

Software picks the divisor for a target frequency. The block only decodes the field. The field is captured only while the run input is low, so a transfer in progress always keeps a steady SCK rate.

Top module: `sck_prescaler`

## Requirements
- R1: After reset, and for as long as `run` stays low, `sck_tick`, `sample_stb` and `shift_stb` all stay low.
- R2: With `EXTENDED`=1, the multiplier M is `prescale[3:0]` and the exponent E is {`prescale[7]`,`prescale[6]`,`prescale[4]`} (bit 7 most significant). The divisor is M shifted left by E. `prescale[5]` has no effect.
- R3: With `EXTENDED`=0, the divisor is twice `prescale[3:0]`. `prescale[7:4]` has no effect, so bit 4 (the legacy 0x10 marker) is optional.
- R4: Any decoded divisor below 4 is raised to 4. This includes multiplier values 0 and 1 in the extended encoding, whatever the exponent.
- R5: The toggle interval H is half the divisor in core cycles. An odd divisor is rounded up, so H = ceil(divisor/2).
- R6: The largest extended field value, 0xDF, gives divisor 1920 and H = 960.
- R7: Count the first cycle in which `run` is high as cycle 0. The first `sck_tick` appears in cycle H-1, and later ones follow every H cycles while `run` stays high.
- R8: The first tick after `run` rises is flagged on `sample_stb`. The second is flagged on `shift_stb`. The two alternate from then on, and every tick carries exactly one of them.
- R9: A change of `prescale` while `run` is high does not change the tick spacing. The new value is taken once `run` has been low for at least one clock edge.
- R10: Dropping `run` clears the count and the edge phase, so the next rise of `run` restarts the timing of R7 and R8 from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prescale | input | 8 | Prescale field, decoded according to `EXTENDED` |
| run | input | 1 | High while strobes are to be produced; low to load the field and clear the count |
| sck_tick | output | 1 | One-cycle strobe at each SCK half-period boundary |
| sample_stb | output | 1 | Marks a tick that is the leading (sample) edge |
| shift_stb | output | 1 | Marks a tick that is the trailing (shift) edge |

## Verification
Each field value is measured twice: the delay from the rise of `run` to the first tick, and the spacing to the second tick. A wrong offset and a wrong rate therefore show up as different failures.

The extended vectors are chosen to tell apart the possible decode faults:
- single exponent bits at each of the positions 4, 6 and 7;
- bit 5 set on its own;
- odd divisors, which expose a missing round-up;
- multipliers of 0 to 3, which exercise the clamp;
- the all-ones maximum.

The legacy vectors repeat one divisor with and without the upper nibble set, to show those bits are ignored. Directed runs then change the field mid-transfer and pulse `run` low mid-count. These separate a captured field from a live one, and a true restart from a resumed count.

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter bit EXTENDED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] prescale,
  input  logic       run,
  output logic       sck_tick,
  output logic       sample_stb,
  output logic       shift_stb
);
  localparam int MUL_W    = 4;
  localparam int EXP_W    = 3;
  localparam int MIN_DIV  = 4;
  localparam int MAX_DIV  = ((1 << MUL_W) - 1) << ((1 << EXP_W) - 1);
  localparam int DIV_W    = $clog2(MAX_DIV + 1);
  localparam int MAX_HALF = (MAX_DIV + 1) / 2;
  localparam int HALF_W   = $clog2(MAX_HALF + 1);

  function automatic logic [HALF_W-1:0] half_of(input logic [7:0] f);
    logic [MUL_W-1:0] mul;
    logic [EXP_W-1:0] ex;
    logic [DIV_W-1:0] n;
    mul = f[3:0];
    ex  = {f[7:6], f[4]};
    if (EXTENDED) n = (mul < 4'd2) ? DIV_W'(MIN_DIV) : (DIV_W'(mul) << ex);
    else          n = DIV_W'({mul, 1'b0});
    if (n < DIV_W'(MIN_DIV)) n = DIV_W'(MIN_DIV);
    n = n + DIV_W'(1);
    return HALF_W'(n >> 1);
  endfunction

  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;
  logic              phase_q;
  logic              hit;

  assign hit        = run && (cnt_q == half_q - HALF_W'(1));
  assign sck_tick   = hit;
  assign sample_stb = hit && !phase_q;
  assign shift_stb  = hit && phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= HALF_W'(MIN_DIV / 2);
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run) begin
      half_q  <= half_of(prescale);
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (hit) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + HALF_W'(1);
    end
  end

  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q >= HALF_W'(MIN_DIV / 2)) && (half_q <= HALF_W'(MAX_HALF))); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_q); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(half_q)); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0 && !phase_q)); // R10
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    sck_tick |=> !sck_tick); // R7
  AST_EDGE_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && $past(run)) |=> (!sample_stb || !run)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !phase_q); // R1
endmodule

// File: tb/sim_sck_prescaler.sv
`timescale 1ns/1ps
module sim_sck_prescaler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pre = 8'h00;
  logic run = 1'b0;
  logic sel = 1'b0;
  logic t0, s0, h0, t1, s1, h1;
  logic tk, smp, shf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sck_prescaler #(.EXTENDED(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .prescale(pre), .run(run),
    .sck_tick(t0), .sample_stb(s0), .shift_stb(h0));
  sck_prescaler #(.EXTENDED(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .prescale(pre), .run(run),
    .sck_tick(t1), .sample_stb(s1), .shift_stb(h1));

  assign tk  = sel ? t1 : t0;
  assign smp = sel ? s1 : s0;
  assign shf = sel ? h1 : h0;

  localparam int NV = 21;
  localparam logic       VL [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,1,1,1,1,1,1,1};
  localparam logic [7:0] VF [NV] = '{8'h00,8'h01,8'h03,8'h05,8'h0F,8'h13,8'h12,8'h45,8'h25,
    8'h8A,8'h5A,8'hD7,8'hDF,8'h0E,8'h1F,8'h12,8'h11,8'h17,8'h07,8'hE7,8'h10};
  localparam int         VH [NV] = '{2,2,2,3,8,3,2,10,3,80,40,448,960,7,15,2,2,7,7,7,2};
  localparam logic [15:0] VT [NV] = '{"R4","R4","R4","R5","R5","R2","R4","R2","R2","R2",
    "R2","R2","R6","R7","R3","R4","R4","R3","R3","R3","R4"};

  task automatic chk(input bit ok, input logic [15:0] tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // Raise run at a negedge; k counts cycles from that one (cycle 0).
  task automatic measure(input logic [7:0] f, input int h, input logic [15:0] tag, input bit reload);
    int k = 0; int first = -1; int second = -1; bit fl = 0; bit sl = 0;
    @(negedge clk);
    if (reload) begin
      run = 1'b0; pre = f;
      repeat (2) @(negedge clk);
    end
    run = 1'b1; #1;
    while (second < 0 && k < 3000) begin
      if (tk) begin
        if (first < 0) begin first = k; fl = smp && !shf; end
        else begin second = k; sl = shf && !smp; end
      end
      step(); k++;
    end
    chk(first == h - 1, "R7", first, h - 1);
    chk(second - first == h, tag, second - first, h);
    chk(fl, "R8", fl, 1);
    chk(sl, "R8", sl, 1);
  endtask

  initial begin
    #(4 * 60000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: quiet in and after reset while run is low
    repeat (3) begin step(); chk(!(t0||s0||h0||t1||s1||h1), "R1", t0, 0); end
    rst_n = 1'b1;
    repeat (5) begin step(); chk(!(t0||s0||h0||t1||s1||h1), "R1", t1, 0); end

    for (int i = 0; i < NV; i++) begin
      sel = VL[i];
      measure(VF[i], VH[i], VT[i], 1'b1);
    end
    @(negedge clk); run = 1'b0;

    // R9: change field mid-run, spacing stays at 3
    sel = 1'b0;
    begin
      int k = 0; int last = -1; int gaps = 0;
      @(negedge clk); pre = 8'h05; repeat (2) @(negedge clk);
      run = 1'b1; #1;
      while (gaps < 3 && k < 100) begin
        if (tk) begin
          if (last >= 0) begin chk(k - last == 3, "R9", k - last, 3); gaps++; end
          else pre = 8'hDF;
          last = k;
        end
        step(); k++;
      end
    end
    // R9: new field taken after run low
    measure(8'hDF, 960, "R9", 1'b1);

    // R10: abort mid-count, restart fresh
    @(negedge clk); run = 1'b0; pre = 8'h45; repeat (2) @(negedge clk);
    run = 1'b1; repeat (6) @(negedge clk);
    run = 1'b0;
    @(negedge clk); #1;
    chk(!tk, "R1", tk, 0);
    measure(8'h45, 10, "R10", 1'b0);
    @(negedge clk); run = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule